// File: doc/BRIEF.md
# Single-Bit Manipulation and Test Unit

This unit performs one operation on a single bit of a byte-wide operand. A 3-bit immediate index picks the bit, and the mask is a one shifted left by that index. The unit offers fourteen operations. Set, clear, invert, store carry and store inverted carry rewrite the bit and ask for the byte to be written back. Test updates the zero flag from the bit. Load and inverted load copy the bit, or its complement, into the carry. The AND, OR and XOR operations, each with a true and an inverted form, combine the bit with the carry and leave the result in the carry.

The caller presents the operand, the index, the opcode and the current carry and zero flags, and pulses `in_valid`. One clock later the unit returns the byte, a write-back enable and both flags, marked by `out_valid`. A flag that an operation does not name passes through unchanged.

A two-state controller sequences the outputs. `ST_IDLE` means no result is pending. `ST_OUT` means the output registers hold a fresh result. The transitions are:
- accept: `ST_IDLE` to `ST_OUT` when `in_valid` is high.
- stream: `ST_OUT` to `ST_OUT` when `in_valid` is high again.
- drain: `ST_OUT` to `ST_IDLE` when `in_valid` is low.
- wait: `ST_IDLE` to `ST_IDLE` when `in_valid` is low.

Top module: `bitop_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after reset, `out_valid`, `wr_en`, `result`, `c_out` and `z_out` are all 0.
- R2: `out_valid` is high in exactly those cycles that directly follow a clock edge at which `in_valid` was high. The result is registered, with one cycle of latency, and back-to-back inputs give back-to-back results.
- R3: Opcode 0 (set) ORs the mask into the operand. Opcode 1 (clear) clears the masked bit. Opcode 2 (invert) flips the masked bit. All three assert `wr_en` and pass `c_in` and `z_in` through.
- R4: Opcode 3 (test) sets `z_out` to the complement of the addressed bit. It passes `c_in` through, returns the operand unchanged and keeps `wr_en` low.
- R5: Opcode 4 (load) sets `c_out` to the addressed bit, and opcode 5 (inverted load) sets it to the bit's complement. Both pass `z_in` through, return the operand unchanged and keep `wr_en` low.
- R6: Opcode 6 (store) writes `c_in` into the addressed bit, and opcode 7 (inverted store) writes its complement. The other bits are kept. Both assert `wr_en` and pass both flags through.
- R7: Opcodes 8/9 give `c_out` = `c_in` AND bit / AND NOT bit. Opcodes 10/11 give OR bit / OR NOT bit. Opcodes 12/13 give XOR bit / XOR NOT bit. All six pass `z_in` through, return the operand unchanged and keep `wr_en` low.
- R8: `wr_en` is high only for opcodes 0, 1, 2, 6 and 7. Opcodes 14 and 15 have no effect: the operand comes back unchanged, both flags pass through and `wr_en` is low.
- R9: In a cycle that follows an edge with `in_valid` low, `result`, `wr_en`, `c_out` and `z_out` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request strobe |
| operand | input | 8 | Byte operand |
| bit_idx | input | 3 | Immediate bit index |
| opcode | input | 4 | Operation code (0 to 15) |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 8 | Byte after the operation |
| wr_en | output | 1 | Byte write-back request |
| c_out | output | 1 | New carry flag |
| z_out | output | 1 | New zero flag |

## Verification
The assertions check the following on every cycle:
- the strobe latency;
- the write-back gating by opcode;
- flag pass-through for the modifying operations;
- the stored bit;
- the test result;
- the hold of outputs when no request was made.

The bench sweeps every opcode, every index, every carry and zero combination and a spread of operand patterns. These sweeps show the full truth table of the carry logic, the integrity of the unaddressed bits, the inert undefined opcodes and the reset values, none of which a per-cycle property covers as a whole.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [3:0] {
        OP_SET  = 4'd0,
        OP_CLR  = 4'd1,
        OP_INV  = 4'd2,
        OP_TST  = 4'd3,
        OP_LD   = 4'd4,
        OP_ILD  = 4'd5,
        OP_ST   = 4'd6,
        OP_IST  = 4'd7,
        OP_AND  = 4'd8,
        OP_IAND = 4'd9,
        OP_OR   = 4'd10,
        OP_IOR  = 4'd11,
        OP_XOR  = 4'd12,
        OP_IXOR = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } bitop_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } bitop_state_e;

endpackage

// File: rtl/bitop_mask.sv
module bitop_mask #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [IDX_W-1:0]  bit_idx,
    output logic [DATA_W-1:0] mask,
    output logic              bit_val
);

    genvar i;
    generate
        for (i = 0; i < DATA_W; i++) begin : g_dec
            assign mask[i] = (bit_idx == IDX_W'(i));
        end
    endgenerate

    assign bit_val = |(operand & mask);

endmodule

// File: rtl/bitop_exec.sv
module bitop_exec
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        opcode,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] mask,
    input  logic              bit_val,
    input  logic              c_in,
    input  logic              z_in,
    output logic [DATA_W-1:0] res,
    output logic              wr,
    output logic              c_nx,
    output logic              z_nx
);

    bitop_op_e op;
    assign op = bitop_op_e'(opcode);

    always_comb begin
        res  = operand;
        wr   = 1'b0;
        c_nx = c_in;
        z_nx = z_in;
        unique case (op)
            OP_SET:  begin res = operand | mask;  wr = 1'b1; end
            OP_CLR:  begin res = operand & ~mask; wr = 1'b1; end
            OP_INV:  begin res = operand ^ mask;  wr = 1'b1; end
            OP_TST:  z_nx = ~bit_val;
            OP_LD:   c_nx = bit_val;
            OP_ILD:  c_nx = ~bit_val;
            OP_ST:   begin
                res = c_in ? (operand | mask) : (operand & ~mask);
                wr  = 1'b1;
            end
            OP_IST:  begin
                res = c_in ? (operand & ~mask) : (operand | mask);
                wr  = 1'b1;
            end
            OP_AND:  c_nx = c_in & bit_val;
            OP_IAND: c_nx = c_in & ~bit_val;
            OP_OR:   c_nx = c_in | bit_val;
            OP_IOR:  c_nx = c_in | ~bit_val;
            OP_XOR:  c_nx = c_in ^ bit_val;
            OP_IXOR: c_nx = c_in ^ ~bit_val;
            default: ;
        endcase
    end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] operand,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [3:0]        opcode,
    input  logic              c_in,
    input  logic              z_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              c_out,
    output logic              z_out
);

    bitop_state_e state_q, state_d;

    logic [DATA_W-1:0] mask;
    logic              bit_val;
    logic [DATA_W-1:0] res_c;
    logic              wr_c, c_c, z_c;

    bitop_mask #(.DATA_W(DATA_W)) u_mask (
        .operand (operand),
        .bit_idx (bit_idx),
        .mask    (mask),
        .bit_val (bit_val)
    );

    bitop_exec #(.DATA_W(DATA_W)) u_exec (
        .opcode  (opcode),
        .operand (operand),
        .mask    (mask),
        .bit_val (bit_val),
        .c_in    (c_in),
        .z_in    (z_in),
        .res     (res_c),
        .wr      (wr_c),
        .c_nx    (c_c),
        .z_nx    (z_c)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_OUT;
            ST_OUT:  if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            wr_en  <= 1'b0;
            c_out  <= 1'b0;
            z_out  <= 1'b0;
        end else if (in_valid) begin
            result <= res_c;
            wr_en  <= wr_c;
            c_out  <= c_c;
            z_out  <= z_c;
        end
    end

    assign out_valid = (state_q == ST_OUT);

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] operand,
    input logic [IDX_W-1:0]  bit_idx,
    input logic [3:0]        opcode,
    input logic              c_in,
    input logic              z_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              wr_en,
    input logic              c_out,
    input logic              z_out
);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    wb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !(opcode inside {4'd0, 4'd1, 4'd2, 4'd6, 4'd7}) |=> !wr_en);

    // R3
    mod_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && opcode inside {4'd0, 4'd1, 4'd2}
        |=> wr_en && c_out == $past(c_in) && z_out == $past(z_in));

    // R6
    store_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && opcode == 4'd6 |=> result[$past(bit_idx)] == $past(c_in));

    // R4
    test_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && opcode == 4'd3
        |=> z_out == !$past(operand[bit_idx]) && result == $past(operand));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(c_out) && $stable(z_out) && $stable(wr_en));

endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .operand   (operand),
    .bit_idx   (bit_idx),
    .opcode    (opcode),
    .c_in      (c_in),
    .z_in      (z_in),
    .out_valid (out_valid),
    .result    (result),
    .wr_en     (wr_en),
    .c_out     (c_out),
    .z_out     (z_out)
);

// File: tb/sim_bitop_unit.sv
module sim_bitop_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] operand = '0;
    logic [2:0] bit_idx = '0;
    logic [3:0] opcode = '0;
    logic       c_in = 1'b0;
    logic       z_in = 1'b0;
    logic       out_valid;
    logic [7:0] result;
    logic       wr_en, c_out, z_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bitop_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .bit_idx(bit_idx), .opcode(opcode), .c_in(c_in), .z_in(z_in),
        .out_valid(out_valid), .result(result), .wr_en(wr_en),
        .c_out(c_out), .z_out(z_out)
    );

    // {out_valid, wr, c, z, result}
    function automatic logic [11:0] model(int op, int opnd, int idx, int c, int z);
        int m, b, r, w, cn, zn;
        m = 1 << idx;
        b = (opnd >> idx) & 1;
        r = opnd; w = 0; cn = c; zn = z;
        case (op)
            0: begin r = opnd | m; w = 1; end
            1: begin r = opnd & ~m; w = 1; end
            2: begin r = opnd ^ m; w = 1; end
            3: zn = 1 - b;
            4: cn = b;
            5: cn = 1 - b;
            6: begin r = c ? (opnd | m) : (opnd & ~m); w = 1; end
            7: begin r = c ? (opnd & ~m) : (opnd | m); w = 1; end
            8: cn = c & b;
            9: cn = c & (1 - b);
            10: cn = c | b;
            11: cn = c | (1 - b);
            12: cn = c ^ b;
            13: cn = c ^ (1 - b);
            default: ;
        endcase
        return {1'b1, w[0], cn[0], zn[0], r[7:0]};
    endfunction

    function automatic string tag(int op);
        if (op <= 2) return "R3";
        if (op == 3) return "R4";
        if (op <= 5) return "R5";
        if (op <= 7) return "R6";
        if (op <= 13) return "R7";
        return "R8";
    endfunction

    task automatic check(string req, logic [11:0] act, logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h (op=%0d idx=%0d opnd=%h c=%0b z=%0b)",
                     req, act, exp, opcode, bit_idx, operand, c_in, z_in);
        end
    endtask

    task automatic drive(int op, int opnd, int idx, int c, int z);
        opcode = op[3:0]; operand = opnd[7:0]; bit_idx = idx[2:0];
        c_in = c[0]; z_in = z[0]; in_valid = 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] prev;
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1", {out_valid, wr_en, c_out, z_out, result}, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 first cycle after reset
        check("R1", {out_valid, wr_en, c_out, z_out, result}, 12'h000);

        // Exhaustive sweep: R3..R8, plus R2 latency and R9 hold
        for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < 8; k++) begin
                for (int idx = 0; idx < 8; idx++) begin
                    for (int cz = 0; cz < 4; cz++) begin
                        int opnd;
                        opnd = (k * 37 + op * 11 + 5) & 8'hFF;
                        if (k == 0) opnd = 8'h00;
                        if (k == 1) opnd = 8'hFF;
                        drive(op, opnd, idx, cz >> 1, cz & 1);
                        @(negedge clk);
                        check(tag(op), {out_valid, wr_en, c_out, z_out, result},
                              model(op, opnd, idx, cz >> 1, cz & 1));
                        prev = {wr_en, c_out, z_out, result};
                        in_valid = 1'b0;
                        operand = ~operand;
                        c_in = ~c_in;
                        z_in = ~z_in;
                        @(negedge clk);
                        // R2 strobe drops, R9 outputs hold
                        check("R9", {out_valid, wr_en, c_out, z_out, result}, {1'b0, prev[10:0]});
                    end
                end
            end
        end

        // R2 back-to-back stream
        for (int n = 0; n < 16; n++) begin
            drive(n, n * 29 + 3, n & 7, n & 1, (n >> 1) & 1);
            @(negedge clk);
            check("R2", {out_valid, wr_en, c_out, z_out, result},
                  model(n, (n * 29 + 3) & 8'hFF, n & 7, n & 1, (n >> 1) & 1));
        end
        in_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2: got out_valid=%0b expected 0", out_valid);
        end

        // R1 reset mid-operation
        drive(0, 8'h00, 3, 1, 1);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", {out_valid, wr_en, c_out, z_out, result}, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule